// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block is a small circular queue of stores that sits between the store execution path and the single write port of a data cache. Stores are allocated in program order. Each one may arrive with its word address or its data still unknown, and a resolution port fills those in later, keyed by the store's tag. A commit input marks the oldest uncommitted entry as final. Committed entries leave for the cache one at a time, oldest first, whenever the write port grants.

In every cycle, one load is compared against all buffered stores that are older than it. The load carries a tag equal to the store tag that was next to be allocated when the load was dispatched, so every store with a smaller sequence number is older. The block returns one of three verdicts:

- **go to cache**: no older store can alias the load.
- **forward**: the data comes from the youngest older store whose address matches.
- **hold**: the load must wait.

A flush discards the speculative, uncommitted part of the queue. Committed entries stay and continue to drain.

Top module: `stbuf_fwd`

## Requirements
- R1: Each accepted allocation gets the tag shown on `st_tag_o` and then increments it by one, modulo 2*DEPTH. `full_o` is high while DEPTH entries are held, and an allocation request seen while full is ignored.
- R2: `wr_req_o` is high only while the oldest entry is committed. It presents that entry's address and data and holds them stable until `wr_gnt_i`; entries leave in allocation order.
- R3: A valid load with every older store address known and no address match gets `ld_bypass_o`.
- R4: A load is held (`ld_hold_o`) while any older buffered store has an unknown address, whether or not the known ones match.
- R5: When several older stores match the load's word address, `ld_fwd_data_o` returns the data of the youngest of them, with `ld_fwd_o` high.
- R6: When the youngest older matching store has no valid data, the load is held, not forwarded.
- R7: Stores whose tag is not older than the load tag take no part in the check. A store is older when (load tag − store tag) mod 2*DEPTH lies in 1..DEPTH.
- R8: `flush_i` drops every uncommitted entry, rewinds `st_tag_o` to the tag after the last committed store, and ignores any allocation in the same cycle. Committed entries stay and drain.
- R9: A resolution write with a store's tag sets that entry's address and/or data, according to the enables, and makes them valid.
- R10: Address comparison covers all AW bits of the word address, so a difference in the top bit alone is not a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop uncommitted entries |
| st_alloc_i | input | 1 | Allocate a store entry |
| st_addr_vld_i | input | 1 | Address known at allocation |
| st_addr_i | input | AW | Word address at allocation |
| st_data_vld_i | input | 1 | Data known at allocation |
| st_data_i | input | DW | Store data at allocation |
| st_tag_o | output | TW | Tag the next allocation receives |
| full_o | output | 1 | All entries occupied |
| res_tag_i | input | TW | Tag of the store being resolved |
| res_addr_en_i | input | 1 | Write the address of that store |
| res_addr_i | input | AW | Resolved word address |
| res_data_en_i | input | 1 | Write the data of that store |
| res_data_i | input | DW | Resolved data |
| commit_i | input | 1 | Commit the oldest uncommitted entry |
| wr_req_o | output | 1 | Cache write request |
| wr_addr_o | output | AW | Cache write word address |
| wr_data_o | output | DW | Cache write data |
| wr_gnt_i | input | 1 | Cache write port accepts the request |
| ld_vld_i | input | 1 | Load probe valid |
| ld_addr_i | input | AW | Load word address |
| ld_tag_i | input | TW | Load age tag |
| ld_bypass_o | output | 1 | Load may read the cache |
| ld_fwd_o | output | 1 | Load served from the buffer |
| ld_fwd_data_o | output | DW | Forwarded data |
| ld_hold_o | output | 1 | Load must wait |

## Verification
The load verdict and the forwarded data are combinational on the current buffer contents, so they are due in the same cycle as the probe. The bench drives each probe one time unit after a rising edge and samples one time unit later, with no clock edge in between.

Allocation, resolution, commit, flush and a granted drain each take effect at the next rising edge. Every check of `st_tag_o`, `full_o` or the cache write port is therefore made after exactly one edge has passed since the stimulus. A refused grant is followed by one further edge, to confirm that the request and its payload persist.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_BYPASS = 2'd1,
    LD_FWD    = 2'd2,
    LD_HOLD   = 2'd3
  } ld_res_e;
endpackage

// File: rtl/stbuf_ptrs.sv
module stbuf_ptrs #(
  parameter int DEPTH = 4,
  localparam int TW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_req_i,
  input  logic          commit_req_i,
  input  logic          drain_i,
  input  logic          flush_i,
  output logic [TW-1:0] head_o,
  output logic [TW-1:0] cmt_o,
  output logic [TW-1:0] tail_o,
  output logic [TW-1:0] occ_o,
  output logic          full_o,
  output logic          alloc_ok_o
);
  logic [TW-1:0] head_q, cmt_q, tail_q, cmt_n;
  logic          cmt_ok;

  assign occ_o      = tail_q - head_q;
  assign full_o     = (occ_o == TW'(DEPTH));
  assign alloc_ok_o = alloc_req_i && !full_o && !flush_i;
  assign cmt_ok     = commit_req_i && (cmt_q != tail_q);
  assign cmt_n      = cmt_q + TW'(cmt_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + TW'(drain_i);
      cmt_q  <= cmt_n;
      tail_q <= flush_i ? cmt_n : tail_q + TW'(alloc_ok_o);
    end
  end

  assign head_o = head_q;
  assign cmt_o  = cmt_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/stbuf_match.sv
module stbuf_match
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1
) (
  input  logic [TW-1:0] head_i,
  input  logic [TW-1:0] occ_i,
  input  logic [TW-1:0] ent_tag_i   [DEPTH],
  input  logic          ent_av_i    [DEPTH],
  input  logic [AW-1:0] ent_addr_i  [DEPTH],
  input  logic          ent_dv_i    [DEPTH],
  input  logic [DW-1:0] ent_data_i  [DEPTH],
  input  logic          ld_vld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [TW-1:0] ld_tag_i,
  output ld_res_e       res_o,
  output logic [DW-1:0] data_o
);
  logic          unk, hit, hit_dv;
  logic [DW-1:0] hit_data;

  // walk oldest to youngest; the last hit is the youngest match
  always_comb begin
    logic [IW-1:0] idx;
    logic [TW-1:0] diff;
    logic          older;
    unk      = 1'b0;
    hit      = 1'b0;
    hit_dv   = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx   = head_i[IW-1:0] + IW'(k);
      diff  = ld_tag_i - ent_tag_i[idx];
      older = (diff != '0) && (diff <= TW'(DEPTH));
      if ((TW'(k) < occ_i) && older) begin
        if (!ent_av_i[idx]) begin
          unk = 1'b1;
        end else if (ent_addr_i[idx] == ld_addr_i) begin
          hit      = 1'b1;
          hit_dv   = ent_dv_i[idx];
          hit_data = ent_data_i[idx];
        end
      end
    end
  end

  always_comb begin
    res_o  = LD_IDLE;
    data_o = '0;
    if (ld_vld_i) begin
      if (unk || (hit && !hit_dv)) begin
        res_o = LD_HOLD;
      end else if (hit) begin
        res_o  = LD_FWD;
        data_o = hit_data;
      end else begin
        res_o = LD_BYPASS;
      end
    end
  end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          st_alloc_i,
  input  logic          st_addr_vld_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic          st_data_vld_i,
  input  logic [DW-1:0] st_data_i,
  output logic [TW-1:0] st_tag_o,
  output logic          full_o,
  input  logic [TW-1:0] res_tag_i,
  input  logic          res_addr_en_i,
  input  logic [AW-1:0] res_addr_i,
  input  logic          res_data_en_i,
  input  logic [DW-1:0] res_data_i,
  input  logic          commit_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_gnt_i,
  input  logic          ld_vld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [TW-1:0] ld_tag_i,
  output logic          ld_bypass_o,
  output logic          ld_fwd_o,
  output logic [DW-1:0] ld_fwd_data_o,
  output logic          ld_hold_o
);
  logic [TW-1:0] head, cmt, tail, occ;
  logic          alloc_ok, drain;
  logic [TW-1:0] ent_tag  [DEPTH];
  logic          ent_av   [DEPTH];
  logic [AW-1:0] ent_addr [DEPTH];
  logic          ent_dv   [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  ld_res_e       ld_res;

  stbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_req_i  (st_alloc_i),
    .commit_req_i (commit_i),
    .drain_i      (drain),
    .flush_i      (flush_i),
    .head_o       (head),
    .cmt_o        (cmt),
    .tail_o       (tail),
    .occ_o        (occ),
    .full_o       (full_o),
    .alloc_ok_o   (alloc_ok)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic upd;
    assign upd = (res_tag_i == ent_tag[i]) && !(alloc_ok && (tail[IW-1:0] == IW'(i)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_tag[i]  <= '0;
        ent_av[i]   <= 1'b0;
        ent_dv[i]   <= 1'b0;
        ent_addr[i] <= '0;
        ent_data[i] <= '0;
      end else if (alloc_ok && (tail[IW-1:0] == IW'(i))) begin
        ent_tag[i]  <= tail;
        ent_av[i]   <= st_addr_vld_i;
        ent_addr[i] <= st_addr_i;
        ent_dv[i]   <= st_data_vld_i;
        ent_data[i] <= st_data_i;
      end else if (upd) begin
        if (res_addr_en_i) begin
          ent_av[i]   <= 1'b1;
          ent_addr[i] <= res_addr_i;
        end
        if (res_data_en_i) begin
          ent_dv[i]   <= 1'b1;
          ent_data[i] <= res_data_i;
        end
      end
    end
  end

  assign wr_req_o  = (head != cmt);
  assign wr_addr_o = ent_addr[head[IW-1:0]];
  assign wr_data_o = ent_data[head[IW-1:0]];
  assign drain     = wr_req_o && wr_gnt_i;
  assign st_tag_o  = tail;

  stbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .head_i     (head),
    .occ_i      (occ),
    .ent_tag_i  (ent_tag),
    .ent_av_i   (ent_av),
    .ent_addr_i (ent_addr),
    .ent_dv_i   (ent_dv),
    .ent_data_i (ent_data),
    .ld_vld_i   (ld_vld_i),
    .ld_addr_i  (ld_addr_i),
    .ld_tag_i   (ld_tag_i),
    .res_o      (ld_res),
    .data_o     (ld_fwd_data_o)
  );

  assign ld_bypass_o = (ld_res == LD_BYPASS);
  assign ld_fwd_o    = (ld_res == LD_FWD);
  assign ld_hold_o   = (ld_res == LD_HOLD);
endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32,
  localparam int TW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [TW-1:0] occ,
  input logic          full_o,
  input logic          st_alloc_i,
  input logic          flush_i,
  input logic [TW-1:0] st_tag_o,
  input logic          wr_req_o,
  input logic          wr_gnt_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          ld_vld_i,
  input logic          ld_bypass_o,
  input logic          ld_fwd_o,
  input logic          ld_hold_o
);
  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= TW'(DEPTH));

  assert_full_refuses_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && st_alloc_i && !flush_i) |=> (st_tag_o == $past(st_tag_o)));

  assert_drain_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_gnt_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_one_verdict_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_vld_i |-> ($countones({ld_bypass_o, ld_fwd_o, ld_hold_o}) == 1));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_vld_i |-> !(ld_bypass_o || ld_fwd_o || ld_hold_o));
endmodule

bind stbuf_fwd stbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .occ         (occ),
  .full_o      (full_o),
  .st_alloc_i  (st_alloc_i),
  .flush_i     (flush_i),
  .st_tag_o    (st_tag_o),
  .wr_req_o    (wr_req_o),
  .wr_gnt_i    (wr_gnt_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .ld_vld_i    (ld_vld_i),
  .ld_bypass_o (ld_bypass_o),
  .ld_fwd_o    (ld_fwd_o),
  .ld_hold_o   (ld_hold_o)
);

// File: tb/sim_stbuf_fwd.sv
`timescale 1ns/1ps
module sim_stbuf_fwd;
  localparam int DEPTH = 4;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int TW = 3;
  localparam logic [1:0] K_BYP = 2'd0, K_FWD = 2'd1, K_HLD = 2'd2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic flush_i = 0, st_alloc_i = 0, st_addr_vld_i = 0, st_data_vld_i = 0;
  logic [AW-1:0] st_addr_i = '0, res_addr_i = '0, ld_addr_i = '0;
  logic [DW-1:0] st_data_i = '0, res_data_i = '0;
  logic [TW-1:0] res_tag_i = '0, ld_tag_i = '0;
  logic res_addr_en_i = 0, res_data_en_i = 0, commit_i = 0, wr_gnt_i = 0, ld_vld_i = 0;
  logic [TW-1:0] st_tag_o;
  logic full_o, wr_req_o, ld_bypass_o, ld_fwd_o, ld_hold_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o, ld_fwd_data_o;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  stbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [TW-1:0] tag;
    logic [1:0]    kind;
    logic [DW-1:0] data;
  } vec_t;

  // buffer at table time: tag0 @0x10=A0, tag1 @0x20=B1, tag2 @0x10=C2
  localparam vec_t TBL [7] = '{
    '{30'h30, 3'd3, K_BYP, 32'h0},              // R3 no match
    '{30'h10, 3'd3, K_FWD, 32'hC2C2_C2C2},      // R5 youngest of two
    '{30'h10, 3'd2, K_FWD, 32'hA0A0_A0A0},      // R7 tag2 not older
    '{30'h20, 3'd3, K_FWD, 32'hB1B1_B1B1},      // R5 single match
    '{30'h10, 3'd0, K_BYP, 32'h0},              // R7 nothing older
    '{30'h2000_0010, 3'd3, K_BYP, 32'h0},       // R10 top bit differs
    '{30'h20, 3'd1, K_BYP, 32'h0}               // R7 only tag0 older
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [TW-1:0] t,
                       input logic [1:0] k, input logic [DW-1:0] d, input string req);
    logic [1:0] ak;
    ld_vld_i = 1; ld_addr_i = a; ld_tag_i = t;
    #1;
    ak = ld_hold_o ? K_HLD : ld_fwd_o ? K_FWD : ld_bypass_o ? K_BYP : 2'd3;
    chk(ak == k, {req, " verdict"}, 64'(ak), 64'(k));
    if (k == K_FWD) chk(ld_fwd_data_o == d, {req, " data"}, 64'(ld_fwd_data_o), 64'(d));
    ld_vld_i = 0;
    #1;
  endtask

  task automatic alloc(input logic av, input logic [AW-1:0] a, input logic dv, input logic [DW-1:0] d);
    st_alloc_i = 1; st_addr_vld_i = av; st_addr_i = a; st_data_vld_i = dv; st_data_i = d;
    tick();
    st_alloc_i = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();
    chk(!full_o && !wr_req_o && st_tag_o == 0, "R1 reset state",
        64'({full_o, wr_req_o, st_tag_o}), 64'h0);

    alloc(1, 30'h10, 1, 32'hA0A0_A0A0);
    alloc(1, 30'h20, 1, 32'hB1B1_B1B1);
    alloc(1, 30'h10, 1, 32'hC2C2_C2C2);
    chk(st_tag_o == 3, "R1 tag sequence", 64'(st_tag_o), 64'd3);
    chk(!wr_req_o, "R2 no request before commit", 64'(wr_req_o), 64'd0);

    for (int i = 0; i < 7; i++)
      probe(TBL[i].addr, TBL[i].tag, TBL[i].kind, TBL[i].data, $sformatf("table row %0d (R3,R5,R7,R10)", i));

    alloc(0, '0, 0, '0);   // tag3, address unknown
    probe(30'h30, 3'd4, K_HLD, '0, "R4 older address unknown");
    probe(30'h10, 3'd4, K_HLD, '0, "R4 hold despite known match");
    probe(30'h30, 3'd3, K_BYP, '0, "R7 unknown store is younger");

    res_tag_i = 3; res_addr_en_i = 1; res_addr_i = 30'h30;
    tick();
    res_addr_en_i = 0;
    probe(30'h30, 3'd4, K_HLD, '0, "R6 match without data");
    probe(30'h10, 3'd4, K_FWD, 32'hC2C2_C2C2, "R5 youngest after resolve");

    res_data_en_i = 1; res_data_i = 32'hD3D3_D3D3;
    tick();
    res_data_en_i = 0;
    probe(30'h30, 3'd4, K_FWD, 32'hD3D3_D3D3, "R9 resolved data forwarded");

    chk(full_o, "R1 full at depth", 64'(full_o), 64'd1);
    alloc(1, 30'h50, 1, 32'h5);
    chk(st_tag_o == 4, "R1 alloc while full ignored", 64'(st_tag_o), 64'd4);
    probe(30'h50, 3'd5, K_BYP, '0, "R1 refused store absent");

    commit_i = 1;
    tick(); tick();
    commit_i = 0;
    chk(wr_req_o && wr_addr_o == 30'h10 && wr_data_o == 32'hA0A0_A0A0, "R2 oldest presented",
        {wr_addr_o[31-:30] , 2'b0, wr_data_o}, {30'h10, 2'b0, 32'hA0A0_A0A0});
    tick();
    chk(wr_req_o && wr_addr_o == 30'h10, "R2 held without grant", 64'(wr_addr_o), 64'h10);

    flush_i = 1; st_alloc_i = 1; st_addr_vld_i = 1; st_addr_i = 30'h60; st_data_vld_i = 1;
    tick();
    flush_i = 0; st_alloc_i = 0;
    chk(st_tag_o == 2, "R8 tag rewound", 64'(st_tag_o), 64'd2);
    chk(!full_o, "R8 space freed", 64'(full_o), 64'd0);
    probe(30'h10, 3'd2, K_FWD, 32'hA0A0_A0A0, "R8 committed kept");
    probe(30'h30, 3'd4, K_BYP, '0, "R8 uncommitted dropped");
    probe(30'h60, 3'd4, K_BYP, '0, "R8 same-cycle alloc ignored");

    wr_gnt_i = 1;
    tick();
    chk(wr_req_o && wr_addr_o == 30'h20 && wr_data_o == 32'hB1B1_B1B1, "R2 second in order",
        64'(wr_addr_o), 64'h20);
    tick();
    wr_gnt_i = 0;
    chk(!wr_req_o, "R2 drained", 64'(wr_req_o), 64'd0);

    alloc(1, 30'h40, 1, 32'hE);
    chk(st_tag_o == 3, "R8 alloc after flush", 64'(st_tag_o), 64'd3);
    probe(30'h40, 3'd3, K_FWD, 32'hE, "R8 new entry usable");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(200000 * 10);
    join_any
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule